// File: doc/BRIEF.md
# Nine-Bit Three-Wire Panel Configuration Serializer

This block writes configuration traffic to an LCD panel controller over a three-wire serial link made of an active-low chip select, a serial clock and one data-out line. The link has no pin that separates commands from parameters. Instead, every transfer is a nine-bit frame, and its leading bit tells the panel how to treat the byte that follows. Upstream logic hands over one byte at a time through a valid/ready request. Each request carries a command-or-parameter flag and a marker that closes the burst. A write is one command frame followed by zero or more parameter frames. Chip select stays low for the whole burst.

The block produces all of the link timing by itself. For each bit the clock is driven low, the data line changes while the clock is low, and the clock is then raised, so the panel can sample on the rising edge. The low and high phases each last `HALF_CYC` system clocks. A quiet gap of `GAP_CYC` system clocks comes before every frame, for commands and parameters alike. Both values are at least one.

A single state machine sequences the work with five states. `ST_IDLE` has chip select released and is ready for a new burst. `ST_GAP` holds chip select low with the clock low during the pre-frame gap. `ST_LOW` is the clock-low phase of a bit, and `ST_HIGH` is the clock-high phase. `ST_WAIT` sits between frames of an open burst with chip select still low.

The transitions are:
- accept: from IDLE or WAIT to GAP, on a handshake.
- gap_done: from GAP to LOW.
- rise: from LOW to HIGH.
- next_bit: from HIGH to LOW, when more bits remain.
- frame_end: from HIGH to WAIT, when the last bit is sent and the burst is still open.
- burst_end: from HIGH to IDLE, when the last bit of a frame marked as closing is sent.

Top module: `tw_cfg_serializer`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sdo` is 0, `busy` is 0 and `req_ready` is 1.
- R2: Every frame is nine bits long. Bit 8 is the type flag, where 0 marks a command byte and 1 marks a parameter byte. Bits 7..0 hold `req_byte`.
- R3: Frame bits go out most significant first, from bit 8 down to bit 0, and each bit is presented before its rising `sclk` edge.
- R4: `sdo` changes only while `sclk` is low and holds its value for the whole high phase.
- R5: Inside a frame, every `sclk` high phase lasts exactly `HALF_CYC` cycles. Every low phase between two bits of the same frame also lasts exactly `HALF_CYC` cycles.
- R6: Before the first rising edge of every frame, `sclk` stays low with `cs_n` asserted for at least `GAP_CYC + HALF_CYC` cycles.
- R7: `cs_n` stays low from the accepted command through every frame of the burst. It rises only after the last bit of the frame marked `req_last`, and `sclk` is never high while `cs_n` is high.
- R8: `req_ready` is high only in the idle state or between frames of an open burst. It is low during the gap and during every bit phase.
- R9: `busy` is high exactly while `cs_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Upstream request is present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_byte | input | 8 | Command or parameter byte |
| req_is_data | input | 1 | 1 for a parameter byte, 0 for a command byte |
| req_last | input | 1 | This frame closes the burst |
| cs_n | output | 1 | Panel chip select, active low |
| sclk | output | 1 | Serial clock; the panel samples on the rising edge |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | A burst is in progress |

## Verification
Some behaviours are checked by assertions on every cycle:
- the clock is never high while chip select is released;
- the data line changes only during a clock-low phase and holds still across a high phase;
- ready is never offered while the clock is high;
- chip select is released only on the cycle right after a clock-high phase;
- the phase and bit counters stay inside their legal ranges.

Other behaviours can only be shown by the bench's scenarios:
- that each captured frame carries the right type flag and byte, in MSB-first order;
- that the phase lengths and pre-frame gaps match the parameters;
- that each chip-select release falls exactly at the end of the frame marked last.

The bench shows these over a sweep of several hundred frames in bursts of one to four words, sent both back-to-back and with idle spacing.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int FRAME_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LOW,
        ST_HIGH,
        ST_WAIT
    } tw_state_e;

endpackage

// File: rtl/tw_timer.sv
module tw_timer #(
    parameter int CW       = 4,
    parameter int MAX_LOAD = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R5
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_LOAD));

endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb,
    output logic         last_bit
);

    localparam int BW = (W > 2) ? $clog2(W) : 1;

    logic [W-1:0]  sh_q;
    logic [BW-1:0] bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            bit_q <= BW'(W - 1);
        end else if (shift) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            bit_q <= bit_q - 1'b1;
        end
    end

    assign msb      = sh_q[W-1];
    assign last_bit = (bit_q == '0);

    // R2
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BW'(W - 1));

    // R3
    no_shift_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last_bit);

endmodule

// File: rtl/tw_cfg_serializer.sv
module tw_cfg_serializer
    import tw_pkg::*;
#(
    parameter int HALF_CYC = 8,
    parameter int GAP_CYC  = 28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [7:0] req_byte,
    input  logic       req_is_data,
    input  logic       req_last,
    output logic       cs_n,
    output logic       sclk,
    output logic       sdo,
    output logic       busy
);

    localparam int HALF_V = (HALF_CYC < 1) ? 1 : HALF_CYC;
    localparam int GAP_V  = (GAP_CYC  < 1) ? 1 : GAP_CYC;
    localparam int MAXD   = (HALF_V > GAP_V) ? HALF_V : GAP_V;
    localparam int CW     = (MAXD > 1) ? $clog2(MAXD) : 1;
    localparam logic [CW-1:0] HALF_LD = CW'(HALF_V - 1);
    localparam logic [CW-1:0] GAP_LD  = CW'(GAP_V - 1);

    tw_state_e     state_q, state_d;
    logic          last_q;
    logic          accept;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_expired;
    logic          s_shift;
    logic          s_msb;
    logic          s_last_bit;

    assign accept = req_valid && req_ready;

    tw_timer #(
        .CW       (CW),
        .MAX_LOAD (MAXD - 1)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    tw_shift #(
        .W (FRAME_W)
    ) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .din      ({req_is_data, req_byte}),
        .shift    (s_shift),
        .msb      (s_msb),
        .last_bit (s_last_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                last_q <= req_last;
            end
        end
    end

    // next state and sequencing controls
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = HALF_LD;
        s_shift = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT: begin
                if (req_valid) begin
                    state_d = ST_GAP;
                    t_load  = 1'b1;
                    t_val   = GAP_LD;
                end
            end
            ST_GAP: begin
                if (t_expired) begin
                    state_d = ST_LOW;
                    t_load  = 1'b1;
                end
            end
            ST_LOW: begin
                if (t_expired) begin
                    state_d = ST_HIGH;
                    t_load  = 1'b1;
                end
            end
            ST_HIGH: begin
                if (t_expired) begin
                    if (s_last_bit) begin
                        state_d = last_q ? ST_IDLE : ST_WAIT;
                    end else begin
                        state_d = ST_LOW;
                        t_load  = 1'b1;
                        s_shift = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        cs_n      = 1'b0;
        sclk      = 1'b0;
        sdo       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                cs_n      = 1'b1;
            end
            ST_WAIT: req_ready = 1'b1;
            ST_GAP:  ;
            ST_LOW:  sdo = s_msb;
            ST_HIGH: begin
                sclk = 1'b1;
                sdo  = s_msb;
            end
            default: cs_n = 1'b1;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // R7
    no_clock_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R7
    release_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(sclk));

    // R4
    data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    // R4
    data_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> !sclk);

    // R8
    no_ready_in_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !req_ready);

endmodule

// File: tb/test_tw_cfg_serializer.sv
module test_tw_cfg_serializer;

    localparam int HALF = 3;
    localparam int GAP  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_byte = '0;
    logic       req_is_data = 1'b0;
    logic       req_last = 1'b0;
    logic       cs_n, sclk, sdo, busy;

    always #2 clk = ~clk;

    tw_cfg_serializer #(.HALF_CYC(HALF), .GAP_CYC(GAP)) i_tw_cfg_serializer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_byte(req_byte), .req_is_data(req_is_data), .req_last(req_last),
        .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .busy(busy)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [8:0] exp_word [0:1023];
    int         burst_end [0:511];
    int nsent = 0;
    int nbursts = 0;

    // monitor state
    int         ncap = 0;
    int         nb = 0;
    int         bit_i = 0;
    int         run = 0;
    logic [8:0] cur_word = '0;
    logic       hi_sdo = 1'b0;
    logic       prev_sclk = 1'b0;
    logic       prev_cs = 1'b1;
    bit         mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            // R9
            chk(busy == !cs_n, "R9 busy vs cs_n", int'(busy), int'(!cs_n));
            if (sclk) begin
                // R8
                chk(req_ready == 1'b0, "R8 ready during bit", int'(req_ready), 0);
            end
            if (!prev_sclk && sclk) begin
                chk(cs_n == 1'b0, "R7 cs_n at rising edge", int'(cs_n), 0);
                if (bit_i == 0) begin
                    chk(run >= GAP + HALF, "R6 pre-frame low", run, GAP + HALF);
                end else begin
                    chk(run == HALF, "R5 low phase", run, HALF);
                end
                cur_word = {cur_word[7:0], sdo};
                hi_sdo = sdo;
                bit_i++;
                run = 1;
            end else if (prev_sclk && !sclk) begin
                chk(run == HALF, "R5 high phase", run, HALF);
                if (bit_i == 9) begin
                    chk(cur_word[8] == exp_word[ncap][8], "R2 type flag",
                        int'(cur_word[8]), int'(exp_word[ncap][8]));
                    chk(cur_word == exp_word[ncap], "R3 frame order",
                        int'(cur_word), int'(exp_word[ncap]));
                    ncap++;
                    bit_i = 0;
                end
                run = 1;
            end else begin
                run++;
            end
            if (sclk && prev_sclk) begin
                chk(sdo == hi_sdo, "R4 data stable high", int'(sdo), int'(hi_sdo));
            end
            if (!prev_cs && cs_n) begin
                chk(ncap == burst_end[nb], "R7 release point", ncap, burst_end[nb]);
                chk(bit_i == 0, "R7 release mid-frame", bit_i, 0);
                nb++;
            end
            prev_sclk = sclk;
            prev_cs = cs_n;
        end
    end

    task automatic send(input logic [7:0] b, input logic d, input logic l);
        exp_word[nsent] = {d, b};
        nsent++;
        if (l) begin
            burst_end[nbursts] = nsent;
            nbursts++;
        end
        req_valid = 1'b1;
        req_byte = b;
        req_is_data = d;
        req_last = l;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin : stim
        int bc = 0;
        repeat (3) @(negedge clk);
        // R1
        chk(cs_n == 1'b1, "R1 cs_n reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk reset", int'(sclk), 0);
        chk(sdo == 1'b0, "R1 sdo reset", int'(sdo), 0);
        chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        chk(req_ready == 1'b1, "R1 ready reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        for (int j = 0; nsent < 520; j++) begin
            int len = 1 + (j % 4);
            for (int k = 0; k < len; k++) begin
                send(8'(bc * 37 + 5), (k != 0), (k == len - 1));
                bc++;
            end
            if (j % 3 == 0) repeat (5) @(negedge clk);
        end
        while (!cs_n) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(ncap == nsent, "R2 frames captured", ncap, nsent);
        chk(nb == nbursts, "R7 bursts released", nb, nbursts);
        chk(busy == 1'b0 && cs_n == 1'b1, "R9 idle at end", int'(busy), 0);
        finish_run();
    end

endmodule